// File: doc/BRIEF.md
# Masked Bus Trigger Comparator Bank

This block watches the address bus and the data bus of a CPU and raises trigger flags when programmed bus conditions occur. It holds a parameterised number of trigger units (ten by default). Each unit picks one of the two buses and compares it against a programmed reference value, with masked bit positions left out. The compare may test for equality, greater-than, less-than or inequality. A unit's result counts only when the current bus cycle is of the kind the unit is told to accept, such as an instruction fetch, a read, a write or a DMA transfer. Each unit also holds an enable vector that selects a set of units. A combined trigger for that unit fires when every selected unit matches in the same bus cycle.

The bus side is a pure observation port. `bus_valid` marks a bus cycle for one clock. There is no ready signal, because the observed bus can never be stalled: every valid cycle is evaluated, and a cycle without `bus_valid` produces no trigger. Software programs the units through a plain 16-bit register port. Writes take effect at the clock edge. Read data is combinational from `reg_addr`. Both sets of trigger flags are registered.

Top module: `bus_trig_bank`

## Requirements
- R1: After reset, every unit register (value, control, mask, combination) reads 0, and `raw_trig` and `comb_trig` are 0.
- R2: Unit k owns byte addresses 8k to 8k+7. The register at offset +0 is the low 16 value bits, +2 is control, +4 is the low 16 mask bits and +6 is the combination enables (bit j selects unit j; bits at or above the unit count read 0). `reg_addr[0]` is ignored. Every mapped register reads back what was written. Addresses at or above 8×units read 0, and writes to them change nothing.
- R3: Control bit 0 selects the bus to compare: 0 compares `bus_addr`, 1 compares `bus_data`.
- R4: Control bits 4:3 select the test of the bus value B against the reference V: 00 B==V, 01 B>V, 10 B<V, 11 B!=V. The test is unsigned and is made on both operands after masking.
- R5: A set mask bit removes that bit from the compare. Bits 19:16 of the reference come from control bits 11:8, and bits 19:16 of the mask come from control bits 15:12.
- R6: The cycle qualifier is the 4-bit code {ctl[6],ctl[5],ctl[2],ctl[1]}. Its values are: 0 fetch, 1 fetch with hold, 2 not fetch, 3 any cycle, 4 not fetch and read, 5 not fetch and write, 6 read, 7 write, 8 not fetch and not DMA, 9 DMA, 10 not DMA, 11 write and not DMA, 12 not fetch and read and not DMA, 13 read and not DMA, 14 read and DMA, 15 write and DMA. A write is a cycle with `bus_read` low.
- R7: `comb_trig[i]` is 1 only when unit i's combination enables are non-zero and every enabled unit has a qualified match in the same bus cycle. An all-zero enable vector never fires.
- R8: `raw_trig` and `comb_trig` reflect the bus cycle sampled at the previous clock edge. A clock without `bus_valid` gives all zeros in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 20 | Address bus value |
| bus_data | input | 20 | Data bus value |
| bus_fetch | input | 1 | Cycle is an instruction fetch |
| bus_hold | input | 1 | Fetch is held |
| bus_read | input | 1 | 1 read, 0 write |
| bus_dma | input | 1 | Cycle is driven by DMA |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| raw_trig | output | 10 | Per-unit qualified match, registered |
| comb_trig | output | 10 | Per-unit combined trigger, registered |

## Verification
The bench builds the block with its default parameters: ten units and a 20-bit bus. With these values the register address is 7 bits wide. Unit indices 10 to 15 therefore decode to windows that exist in the address space but have no unit behind them, so the bench can show that such writes do not alias into units 0 to 7. The 20-bit width also puts the reference and mask nibble packed into control bits 15:8 into use, which lets the bench test masking of the upper address nibble and a large unsigned magnitude.

// File: rtl/bus_trig_pkg.sv
package bus_trig_pkg;

  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    CMP_EQ = 2'b00,
    CMP_GT = 2'b01,
    CMP_LT = 2'b10,
    CMP_NE = 2'b11
  } cmp_kind_t;

  typedef enum logic [1:0] {
    SEL_VAL  = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_MSK  = 2'd2,
    SEL_COMB = 2'd3
  } reg_sel_t;

  // Bus-cycle qualifier: 4-bit code against the cycle-type strobes.
  function automatic logic cycle_ok(input logic [3:0] code, input logic fetch,
                                    input logic hold, input logic rd, input logic dma);
    logic wr;
    wr = ~rd;
    case (code)
      4'd0:    cycle_ok = fetch;
      4'd1:    cycle_ok = fetch & hold;
      4'd2:    cycle_ok = ~fetch;
      4'd3:    cycle_ok = 1'b1;
      4'd4:    cycle_ok = ~fetch & rd;
      4'd5:    cycle_ok = ~fetch & wr;
      4'd6:    cycle_ok = rd;
      4'd7:    cycle_ok = wr;
      4'd8:    cycle_ok = ~fetch & ~dma;
      4'd9:    cycle_ok = dma;
      4'd10:   cycle_ok = ~dma;
      4'd11:   cycle_ok = wr & ~dma;
      4'd12:   cycle_ok = ~fetch & rd & ~dma;
      4'd13:   cycle_ok = rd & ~dma;
      4'd14:   cycle_ok = rd & dma;
      default: cycle_ok = wr & dma;
    endcase
  endfunction

endpackage

// File: rtl/bus_trig_unit.sv
module bus_trig_unit
  import bus_trig_pkg::*;
#(
  parameter int BUS_W     = 20,
  parameter int NUM_UNITS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           sel,
  input  logic [REG_W-1:0]     wr_data,
  output logic [REG_W-1:0]     rd_data,
  input  logic                 bus_valid,
  input  logic [BUS_W-1:0]     bus_addr,
  input  logic [BUS_W-1:0]     bus_data,
  input  logic                 bus_fetch,
  input  logic                 bus_hold,
  input  logic                 bus_read,
  input  logic                 bus_dma,
  output logic                 match,
  output logic [NUM_UNITS-1:0] comb_en
);

  // Upper reference/mask bits live in control 11:8 and 15:12 (BUS_W of 17..20).
  localparam int HI_W = BUS_W - REG_W;

  logic [REG_W-1:0]     val_lo, ctl, msk_lo;
  logic [NUM_UNITS-1:0] en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_lo <= '0;
      ctl    <= '0;
      msk_lo <= '0;
      en     <= '0;
    end else if (wr_en) begin
      case (reg_sel_t'(sel))
        SEL_VAL: val_lo <= wr_data;
        SEL_CTL: ctl    <= wr_data;
        SEL_MSK: msk_lo <= wr_data;
        default: en     <= wr_data[NUM_UNITS-1:0];
      endcase
    end
  end

  logic [BUS_W-1:0] ref_v, mask_v, bus_v, a_m, b_m;
  logic             cmp_hit;
  logic [REG_W-1:0] en_wide;

  always_comb begin
    ref_v  = {ctl[8 +: HI_W], val_lo};
    mask_v = {ctl[12 +: HI_W], msk_lo};
    bus_v  = ctl[0] ? bus_data : bus_addr;
    a_m    = bus_v & ~mask_v;
    b_m    = ref_v & ~mask_v;
    case (cmp_kind_t'(ctl[4:3]))
      CMP_EQ:  cmp_hit = (a_m == b_m);
      CMP_GT:  cmp_hit = (a_m > b_m);
      CMP_LT:  cmp_hit = (a_m < b_m);
      default: cmp_hit = (a_m != b_m);
    endcase
    match = bus_valid & cmp_hit &
            cycle_ok({ctl[6], ctl[5], ctl[2], ctl[1]}, bus_fetch, bus_hold, bus_read, bus_dma);
  end

  always_comb begin
    en_wide = '0;
    en_wide[NUM_UNITS-1:0] = en;
    case (reg_sel_t'(sel))
      SEL_VAL: rd_data = val_lo;
      SEL_CTL: rd_data = ctl;
      SEL_MSK: rd_data = msk_lo;
      default: rd_data = en_wide;
    endcase
  end

  assign comb_en = en;

endmodule

// File: rtl/bus_trig_combine.sv
module bus_trig_combine #(
  parameter int NUM_UNITS = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_UNITS-1:0]           match,
  input  logic [NUM_UNITS*NUM_UNITS-1:0] en_flat,
  output logic [NUM_UNITS-1:0]           raw_trig,
  output logic [NUM_UNITS-1:0]           comb_trig
);

  logic [NUM_UNITS-1:0] comb_d;

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_comb
    logic [NUM_UNITS-1:0] en_i;
    assign en_i      = en_flat[i*NUM_UNITS +: NUM_UNITS];
    assign comb_d[i] = (|en_i) && ((match & en_i) == en_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_trig  <= '0;
      comb_trig <= '0;
    end else begin
      raw_trig  <= match;
      comb_trig <= comb_d;
    end
  end

endmodule

// File: rtl/bus_trig_bank.sv
module bus_trig_bank
  import bus_trig_pkg::*;
#(
  parameter int NUM_UNITS = 10,
  parameter int BUS_W     = 20,
  parameter int AW        = $clog2(NUM_UNITS * 8)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic [BUS_W-1:0]     bus_addr,
  input  logic [BUS_W-1:0]     bus_data,
  input  logic                 bus_fetch,
  input  logic                 bus_hold,
  input  logic                 bus_read,
  input  logic                 bus_dma,
  input  logic                 reg_wr_en,
  input  logic [AW-1:0]        reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic [NUM_UNITS-1:0] raw_trig,
  output logic [NUM_UNITS-1:0] comb_trig
);

  localparam int UW = AW - 3;

  logic [UW-1:0]                  unit_idx;
  logic [1:0]                     sel;
  logic [NUM_UNITS-1:0]           match;
  logic [NUM_UNITS*NUM_UNITS-1:0] en_flat;
  logic [REG_W-1:0]               rd_arr [NUM_UNITS];

  assign unit_idx = reg_addr[AW-1:3];
  assign sel      = reg_addr[2:1];

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
    bus_trig_unit #(.BUS_W(BUS_W), .NUM_UNITS(NUM_UNITS)) u_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en && (unit_idx == UW'(k))),
      .sel       (sel),
      .wr_data   (reg_wdata),
      .rd_data   (rd_arr[k]),
      .bus_valid (bus_valid),
      .bus_addr  (bus_addr),
      .bus_data  (bus_data),
      .bus_fetch (bus_fetch),
      .bus_hold  (bus_hold),
      .bus_read  (bus_read),
      .bus_dma   (bus_dma),
      .match     (match[k]),
      .comb_en   (en_flat[k*NUM_UNITS +: NUM_UNITS])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NUM_UNITS; k++)
      if (unit_idx == UW'(k)) reg_rdata = rd_arr[k];
  end

  bus_trig_combine #(.NUM_UNITS(NUM_UNITS)) u_comb (
    .clk       (clk),
    .rst_n     (rst_n),
    .match     (match),
    .en_flat   (en_flat),
    .raw_trig  (raw_trig),
    .comb_trig (comb_trig)
  );

endmodule

// File: rtl/bus_trig_bank_chk.sv
module bus_trig_bank_chk #(
  parameter int NUM_UNITS = 10,
  parameter int AW        = 7
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_valid,
  input logic [AW-1:0]                  reg_addr,
  input logic [15:0]                    reg_rdata,
  input logic [NUM_UNITS-1:0]           raw_trig,
  input logic [NUM_UNITS-1:0]           comb_trig,
  input logic [NUM_UNITS*NUM_UNITS-1:0] en_flat
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (raw_trig == '0 && comb_trig == '0)); // R1

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, reg_addr[AW-1:3]} >= (AW-2)'(NUM_UNITS)) |-> (reg_rdata == '0)); // R2

  AST_RAW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> (raw_trig == '0)); // R8

  AST_COMB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> (comb_trig == '0)); // R8

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_chk
    AST_COMB_ALL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      comb_trig[i] |-> ($past(en_flat[i*NUM_UNITS +: NUM_UNITS]) != '0 &&
        (raw_trig & $past(en_flat[i*NUM_UNITS +: NUM_UNITS])) ==
          $past(en_flat[i*NUM_UNITS +: NUM_UNITS]))); // R7
  end

endmodule

bind bus_trig_bank bus_trig_bank_chk #(.NUM_UNITS(NUM_UNITS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .raw_trig  (raw_trig),
  .comb_trig (comb_trig),
  .en_flat   (en_flat)
);

// File: tb/bus_trig_bank_test.sv
`timescale 1ns/1ps
module bus_trig_bank_test;

  localparam int N  = 10;
  localparam int BW = 20;
  localparam int AW = 7;

  logic          clk = 0, rst_n = 0;
  logic          bus_valid = 0, bus_fetch = 0, bus_hold = 0, bus_read = 0, bus_dma = 0;
  logic [BW-1:0] bus_addr = '0, bus_data = '0;
  logic          reg_wr_en = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [15:0]   reg_wdata = '0, reg_rdata;
  logic [N-1:0]  raw_trig, comb_trig;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  bus_trig_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_fetch(bus_fetch), .bus_hold(bus_hold),
    .bus_read(bus_read), .bus_dma(bus_dma), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .raw_trig(raw_trig), .comb_trig(comb_trig)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; bus_valid = 0; reg_wr_en = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); reg_wr_en = 1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic rdchk(input string req, input int a, input logic [15:0] exp);
    @(negedge clk); reg_addr = AW'(a); #1;
    chk(req, 32'(reg_rdata), 32'(exp));
  endtask

  // One bus cycle; on return the registered flags show its result.
  task automatic cyc(input logic [BW-1:0] a, input logic [BW-1:0] d,
                     input logic f, input logic h, input logic r, input logic m);
    @(negedge clk);
    bus_valid = 1; bus_addr = a; bus_data = d;
    bus_fetch = f; bus_hold = h; bus_read = r; bus_dma = m;
    @(negedge clk); bus_valid = 0; #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 raw", 32'(raw_trig), 0);
    chk("R1 comb", 32'(comb_trig), 0);
    rdchk("R1 ctl", 3*8+2, 16'h0);
    rdchk("R1 comb reg", 7*8+6, 16'h0);
  endtask

  task automatic t_regmap();
    do_reset();
    wr(4*8+0, 16'h1234);
    rdchk("R2 value", 4*8+0, 16'h1234);
    wr(9*8+2, 16'hABCD);
    rdchk("R2 control", 9*8+2, 16'hABCD);
    wr(1*8+4, 16'h0FF0);
    rdchk("R2 mask", 1*8+4, 16'h0FF0);
    wr(1*8+6, 16'hFFFF);
    rdchk("R2 comb width", 1*8+6, 16'h03FF);
    rdchk("R2 odd addr", 4*8+1, 16'h1234);
    wr(10*8+0, 16'h5555);
    rdchk("R2 unmapped read", 10*8+0, 16'h0);
    rdchk("R2 no alias u2", 2*8+0, 16'h0);
    rdchk("R2 no alias u0", 0, 16'h0);
  endtask

  task automatic t_bus_sel();
    do_reset();
    wr(0, 16'h0100);
    wr(2, 16'h0006);
    cyc(20'h00100, 20'h00000, 1, 0, 1, 0);
    chk("R3 addr bus hit", 32'(raw_trig[0]), 1);
    cyc(20'h00000, 20'h00100, 1, 0, 1, 0);
    chk("R3 addr bus miss", 32'(raw_trig[0]), 0);
    wr(2, 16'h0007);
    cyc(20'h00100, 20'h00555, 1, 0, 1, 0);
    chk("R3 data bus miss", 32'(raw_trig[0]), 0);
    cyc(20'h00000, 20'h00100, 1, 0, 1, 0);
    chk("R3 data bus hit", 32'(raw_trig[0]), 1);
  endtask

  task automatic t_compare();
    do_reset();
    wr(8+0, 16'h0500);
    wr(8+2, 16'h000E);
    cyc(20'h00501, 0, 0, 0, 1, 0); chk("R4 gt above", 32'(raw_trig[1]), 1);
    cyc(20'h00500, 0, 0, 0, 1, 0); chk("R4 gt equal", 32'(raw_trig[1]), 0);
    cyc(20'hF0000, 0, 0, 0, 1, 0); chk("R4 gt unsigned", 32'(raw_trig[1]), 1);
    wr(8+2, 16'h0016);
    cyc(20'h004FF, 0, 0, 0, 1, 0); chk("R4 lt below", 32'(raw_trig[1]), 1);
    cyc(20'hF0000, 0, 0, 0, 1, 0); chk("R4 lt unsigned", 32'(raw_trig[1]), 0);
    wr(8+2, 16'h001E);
    cyc(20'h00500, 0, 0, 0, 1, 0); chk("R4 ne equal", 32'(raw_trig[1]), 0);
    cyc(20'h00501, 0, 0, 0, 1, 0); chk("R4 ne differ", 32'(raw_trig[1]), 1);
    wr(8+2, 16'h000E);
    wr(8+4, 16'h00FF);
    cyc(20'h005FF, 0, 0, 0, 1, 0); chk("R4 gt masked equal", 32'(raw_trig[1]), 0);
    cyc(20'h00600, 0, 0, 0, 1, 0); chk("R4 gt masked above", 32'(raw_trig[1]), 1);
  endtask

  task automatic t_mask();
    do_reset();
    wr(16+0, 16'h1234);
    wr(16+2, 16'hF306);
    cyc(20'h81234, 0, 0, 0, 1, 0); chk("R5 top nibble masked", 32'(raw_trig[2]), 1);
    cyc(20'h81235, 0, 0, 0, 1, 0); chk("R5 low bit differs", 32'(raw_trig[2]), 0);
    wr(16+2, 16'h0306);
    cyc(20'h81234, 0, 0, 0, 1, 0); chk("R5 nibble compared", 32'(raw_trig[2]), 0);
    cyc(20'h31234, 0, 0, 0, 1, 0); chk("R5 ref high nibble", 32'(raw_trig[2]), 1);
  endtask

  task automatic qual(input logic [15:0] code, input string req,
                      input logic f, input logic h, input logic r, input logic m,
                      input logic exp);
    wr(24+2, 16'hF000 | code);
    cyc(20'h12345, 0, f, h, r, m);
    chk(req, 32'(raw_trig[3]), 32'(exp));
  endtask

  task automatic t_qual();
    do_reset();
    wr(24+4, 16'hFFFF);
    qual(16'h0066, "R6 dma write hit",     0, 0, 0, 1, 1);
    qual(16'h0066, "R6 dma write on read", 0, 0, 1, 1, 0);
    qual(16'h0066, "R6 dma write no dma",  0, 0, 0, 0, 0);
    qual(16'h0024, "R6 read hit",          0, 0, 1, 0, 1);
    qual(16'h0024, "R6 read on write",     0, 0, 0, 0, 0);
    qual(16'h0042, "R6 dma any",           0, 0, 1, 1, 1);
    qual(16'h0042, "R6 dma none",          0, 0, 1, 0, 0);
    qual(16'h0000, "R6 fetch hit",         1, 0, 1, 0, 1);
    qual(16'h0000, "R6 fetch miss",        0, 0, 1, 0, 0);
    qual(16'h0002, "R6 fetch no hold",     1, 0, 1, 0, 0);
    qual(16'h0002, "R6 fetch hold",        1, 1, 1, 0, 1);
    qual(16'h0006, "R6 dont care",         0, 0, 0, 1, 1);
    qual(16'h0044, "R6 not dma on dma",    0, 0, 1, 1, 0);
    qual(16'h0060, "R6 nf rd nd hit",      0, 0, 1, 0, 1);
  endtask

  task automatic t_combine();
    do_reset();
    wr(0+4, 16'hFFFF); wr(0+2, 16'hF000);
    wr(8+4, 16'hFFFF); wr(8+2, 16'hF024);
    wr(5*8+6, 16'h0003);
    wr(6*8+6, 16'h0004);
    wr(2*8+0, 16'h0001);
    cyc(20'h00000, 0, 1, 0, 1, 0);
    chk("R7 both match", 32'(comb_trig), 32'(10'b00_0010_0000));
    cyc(20'h00000, 0, 1, 0, 0, 0);
    chk("R7 one missing", 32'(comb_trig), 0);
    cyc(20'h00001, 0, 1, 0, 0, 0);
    chk("R7 single enable", 32'(comb_trig), 32'(10'b00_0100_0000));
  endtask

  task automatic t_latency();
    do_reset();
    wr(0+4, 16'hFFFF); wr(0+2, 16'hF006);
    @(negedge clk); bus_valid = 1; #1;
    chk("R8 before edge", 32'(raw_trig[0]), 0);
    @(negedge clk); bus_valid = 0; #1;
    chk("R8 after one edge", 32'(raw_trig[0]), 1);
    @(negedge clk); #1;
    chk("R8 idle clears", 32'(raw_trig), 0);
  endtask

  initial begin
    t_reset();
    t_regmap();
    t_bus_sel();
    t_compare();
    t_mask();
    t_qual();
    t_combine();
    t_latency();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule